// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 16-bit virtual address into a 20-bit physical address by walking a two-level translation table held in memory. A one-cycle start pulse hands it the virtual address and the base of the root table; the walker then issues one or two dependent reads on a simple request/response memory port. The first read fetches a root entry and the second fetches a leaf entry. The walker ends with a one-cycle done pulse carrying either the physical address or a fault.

The virtual address is split by bit position. Bits [15:14] select the root entry, bits [13:12] select the leaf entry, and bits [11:0] are the page offset, which passes through unchanged. Every table entry is a 16-bit word with three fields. Bit 15 is the present flag, bit 14 is the large-page flag, and bits [11:0] hold a word address or a frame number; the frame number sits in the low 8 bits. A root entry with the large-page flag set maps a 16 KB region directly, and no leaf read is made. Loading a different root base at start selects a different address space.

Memory reads are word-addressed. The responder may answer any number of cycles after the request, as long as it answers no earlier than the cycle after the request cycle.

Top module: `pgw_walker`

## Requirements
- R1: While reset is held, and in the first cycle after it, done, fault and mem_req are low.
- R2: A start pulse seen while idle causes a one-cycle mem_req in the next cycle, with mem_addr = root_base + va[15:14]. The address and root base are captured at that start.
- R3: If the root entry response has bit 15 = 1 and bit 14 = 0, the walker issues a one-cycle mem_req in the cycle after the response, with mem_addr = entry[11:0] + va[13:12].
- R4: If the leaf entry response has bit 15 = 1, done pulses for one cycle in the cycle after the response. In that cycle fault is low and pa = {entry[7:0], va[11:0]}. With root entries 0x8100, 0x8400, 0x8300, 0x8700 and the table at 0x300 holding frames 2, 1, 4, 3, address 39758 gives 6990.
- R5: An entry with bit 15 = 0 at either level causes done and fault together for one cycle in the cycle after the response, with pa = 0. No further read is issued.
- R6: If the root entry response has bits 15 and 14 both set, the walker makes no leaf read. Done pulses in the cycle after the response with fault low and pa = {entry[7:2], va[13:0]}.
- R7: A start pulse during a walk is ignored, and so are changes to va and root_base during a walk. The walk's reads and result depend only on the values captured at its start.
- R8: A response pulse (mem_rvalid) is ignored when it arrives while the walker is idle, or in the same cycle as mem_req.
- R9: The walker waits any number of cycles for each response and produces no output while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a translation (one-cycle pulse) |
| va | input | 16 | Virtual address to translate |
| root_base | input | 12 | Word address of the root table |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 12 | Word address of the entry to read |
| mem_rvalid | input | 1 | Read data is present this cycle |
| mem_rdata | input | 16 | Table entry returned by memory |
| done | output | 1 | Translation finished (one-cycle pulse) |
| fault | output | 1 | Translation failed; valid with done |
| pa | output | 20 | Physical address; valid with done |

## Verification
A wrong walk state shows up at the memory port within one cycle of the response that should have moved it on. Such a state produces a missing or extra mem_req, a leaf read after a large-page entry, or a request aimed at the wrong table row. A wrong captured address or root shows up only at done, as a wrong pa, so the bench changes va and root_base in the middle of walks. The bench also varies response latency and sends stray responses, so that a walker which counts cycles instead of waiting for responses drifts out of step at once.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    localparam int VA_W     = 16;
    localparam int L1_W     = 2;
    localparam int L2_W     = 2;
    localparam int OFF_W    = 12;
    localparam int MA_W     = 12;
    localparam int ENT_W    = 16;
    localparam int FRAME_W  = 8;
    localparam int PA_W     = FRAME_W + OFF_W;
    localparam int HUGE_W   = L2_W + OFF_W;
    localparam int PRES_BIT = ENT_W - 1;
    localparam int HUGE_BIT = ENT_W - 2;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_RD_L1 = 2'd1,
        W_RD_L2 = 2'd2
    } walk_state_e;

    typedef struct packed {
        logic [L1_W-1:0]  l1;
        logic [L2_W-1:0]  l2;
        logic [OFF_W-1:0] off;
    } va_t;

    typedef struct packed {
        logic            present;
        logic            huge;
        logic [MA_W-1:0] field;
    } ent_t;

    function automatic ent_t decode_entry(input logic [ENT_W-1:0] raw);
        ent_t e;
        e.present = raw[PRES_BIT];
        e.huge    = raw[HUGE_BIT];
        e.field   = raw[MA_W-1:0];
        return e;
    endfunction

endpackage

// File: rtl/pgw_entry_dec.sv
module pgw_entry_dec
    import pgw_pkg::*;
(
    input  logic [ENT_W-1:0] raw,
    output ent_t             ent
);
    always_comb ent = decode_entry(raw);
endmodule

// File: rtl/pgw_idx_addr.sv
module pgw_idx_addr
    import pgw_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic [MA_W-1:0]  base,
    input  logic [IDX_W-1:0] idx,
    output logic [MA_W-1:0]  addr
);
    localparam int PAD_W = MA_W - IDX_W;
    always_comb addr = base + {{PAD_W{1'b0}}, idx};
endmodule

// File: rtl/pgw_pa_build.sv
module pgw_pa_build
    import pgw_pkg::*;
(
    input  va_t             vaddr,
    input  ent_t            ent,
    output logic [PA_W-1:0] pa_page,
    output logic [PA_W-1:0] pa_huge
);
    localparam int HFR_W = PA_W - HUGE_W;
    logic [FRAME_W-1:0] frame;
    always_comb begin
        frame   = ent.field[FRAME_W-1:0];
        pa_page = {frame, vaddr.off};
        pa_huge = {frame[FRAME_W-1 -: HFR_W], vaddr.l2, vaddr.off};
    end
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
    import pgw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VA_W-1:0]  va,
    input  logic [MA_W-1:0]  root_base,
    output logic             mem_req,
    output logic [MA_W-1:0]  mem_addr,
    input  logic             mem_rvalid,
    input  logic [ENT_W-1:0] mem_rdata,
    output logic             done,
    output logic             fault,
    output logic [PA_W-1:0]  pa
);
    walk_state_e     state;
    va_t             va_q;
    va_t             va_in;
    ent_t            ent;
    logic [MA_W-1:0] l1_addr;
    logic [MA_W-1:0] l2_addr;
    logic [PA_W-1:0] pa_page;
    logic [PA_W-1:0] pa_huge;
    logic            rsp_ok;
    logic            busy;

    assign va_in  = va_t'(va);
    assign rsp_ok = mem_rvalid && !mem_req;
    assign busy   = (state != W_IDLE);

    pgw_entry_dec u_dec (
        .raw (mem_rdata),
        .ent (ent)
    );

    pgw_idx_addr #(.IDX_W(L1_W)) u_l1_addr (
        .base (root_base),
        .idx  (va_in.l1),
        .addr (l1_addr)
    );

    pgw_idx_addr #(.IDX_W(L2_W)) u_l2_addr (
        .base (ent.field),
        .idx  (va_q.l2),
        .addr (l2_addr)
    );

    pgw_pa_build u_pa (
        .vaddr   (va_q),
        .ent     (ent),
        .pa_page (pa_page),
        .pa_huge (pa_huge)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= W_IDLE;
            va_q     <= '0;
            mem_req  <= 1'b0;
            mem_addr <= '0;
            done     <= 1'b0;
            fault    <= 1'b0;
            pa       <= '0;
        end else begin
            mem_req <= 1'b0;
            done    <= 1'b0;
            fault   <= 1'b0;
            unique case (state)
                W_IDLE: begin
                    if (start) begin
                        va_q     <= va_in;
                        mem_addr <= l1_addr;
                        mem_req  <= 1'b1;
                        state    <= W_RD_L1;
                    end
                end
                W_RD_L1: begin
                    if (rsp_ok) begin
                        if (!ent.present) begin
                            done  <= 1'b1;
                            fault <= 1'b1;
                            pa    <= '0;
                            state <= W_IDLE;
                        end else if (ent.huge) begin
                            done  <= 1'b1;
                            pa    <= pa_huge;
                            state <= W_IDLE;
                        end else begin
                            mem_addr <= l2_addr;
                            mem_req  <= 1'b1;
                            state    <= W_RD_L2;
                        end
                    end
                end
                W_RD_L2: begin
                    if (rsp_ok) begin
                        done  <= 1'b1;
                        fault <= !ent.present;
                        pa    <= ent.present ? pa_page : '0;
                        state <= W_IDLE;
                    end
                end
                default: state <= W_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pgw_walker_chk.sv
module pgw_walker_chk
    import pgw_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            busy,
    input logic            mem_req,
    input logic            done,
    input logic            fault,
    input logic [PA_W-1:0] pa
);
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done && !fault && !mem_req));

    a_r2_start_issues_read: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> mem_req);

    a_r2_req_single_cycle: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    a_r4_done_single_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r4_idle_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !mem_req));

    a_r5_fault_only_with_done: assert property (@(posedge clk) disable iff (rst)
        fault |-> done);

    a_r5_fault_zero_pa: assert property (@(posedge clk) disable iff (rst)
        fault |-> (pa == '0));

    a_r8_no_done_from_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !done);

    a_r9_no_read_while_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !mem_req);
endmodule

bind pgw_walker pgw_walker_chk i_pgw_walker_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .mem_req (mem_req),
    .done    (done),
    .fault   (fault),
    .pa      (pa)
);

// File: tb/test_pgw_walker.sv
module test_pgw_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] va = '0;
    logic [11:0] root_base = '0;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        mem_req;
    logic [11:0] mem_addr;
    logic        done;
    logic        fault;
    logic [19:0] pa;

    pgw_walker i_pgw_walker (
        .clk (clk), .rst (rst), .start (start), .va (va), .root_base (root_base),
        .mem_req (mem_req), .mem_addr (mem_addr), .mem_rvalid (mem_rvalid),
        .mem_rdata (mem_rdata), .done (done), .fault (fault), .pa (pa)
    );

    always #10 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;

    logic [15:0] mem [int];

    // sequencer-controlled next inputs
    logic        n_rst = 1'b1;
    logic        n_start = 1'b0;
    logic [15:0] n_va = '0;
    logic [11:0] n_root = '0;
    int          lat = 1;
    bit          early_junk = 0;
    bit          stray_idle = 0;
    string       tag = "R1";

    // responder state
    int          cnt = 0;
    logic [11:0] raddr = '0;

    // reference model state
    int          ms = 0;
    logic [15:0] m_va = '0;
    logic        e_req = 0, e_done = 0, e_fault = 0;
    logic [11:0] e_addr = '0;
    logic [19:0] e_pa = '0;

    // observations
    int          done_cnt = 0;
    logic        got_fault = 0;
    logic [19:0] got_pa = '0;

    function automatic logic [15:0] rdmem(input logic [11:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0000;
    endfunction

    task automatic chk(input string t, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", t, act, exp);
        end
    endtask

    task automatic cycle();
        logic        rv;
        logic [15:0] rd;
        logic        q_req, q_done, q_fault;
        @(negedge clk);
        // per-cycle comparison against the reference model
        vectors++;
        if (done !== e_done || fault !== e_fault || mem_req !== e_req ||
            (e_req && mem_addr !== e_addr) || (e_done && pa !== e_pa)) begin
            miscompares++;
            $display("FAIL %s: actual done=%b fault=%b req=%b addr=0x%0h pa=0x%0h expected done=%b fault=%b req=%b addr=0x%0h pa=0x%0h",
                     tag, done, fault, mem_req, mem_addr, pa, e_done, e_fault, e_req, e_addr, e_pa);
        end
        if (done === 1'b1) begin
            done_cnt++;
            got_fault = fault;
            got_pa = pa;
        end
        // memory responder
        rv = 1'b0;
        rd = 16'h0000;
        if (mem_req === 1'b1) begin
            cnt = lat;
            raddr = mem_addr;
            if (early_junk) begin rv = 1'b1; rd = 16'hFFFF; end
        end else if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin rv = 1'b1; rd = rdmem(raddr); end
        end else if (stray_idle) begin
            rv = 1'b1;
            rd = 16'h8ABC;
        end
        // reference model step for the coming edge
        q_req = 0; q_done = 0; q_fault = 0;
        if (n_rst) begin
            ms = 0;
            e_addr = '0;
            e_pa = '0;
        end else begin
            case (ms)
                0: if (n_start) begin
                    q_req = 1;
                    e_addr = n_root + {10'd0, n_va[15:14]};
                    m_va = n_va;
                    ms = 1;
                end
                1: if (rv && !e_req) begin
                    if (!rd[15]) begin
                        q_done = 1; q_fault = 1; e_pa = '0; ms = 0;
                    end else if (rd[14]) begin
                        q_done = 1; e_pa = {rd[7:2], m_va[13:0]}; ms = 0;
                    end else begin
                        q_req = 1; e_addr = rd[11:0] + {10'd0, m_va[13:12]}; ms = 2;
                    end
                end
                default: if (rv && !e_req) begin
                    q_done = 1;
                    q_fault = !rd[15];
                    e_pa = rd[15] ? {rd[7:0], m_va[11:0]} : 20'd0;
                    ms = 0;
                end
            endcase
        end
        e_req = q_req; e_done = q_done; e_fault = q_fault;
        // drive the design
        rst = n_rst;
        start = n_start;
        va = n_va;
        root_base = n_root;
        mem_rvalid = rv;
        mem_rdata = rd;
    endtask

    task automatic gold(input logic [15:0] v, input logic [11:0] r,
                        output logic f, output logic [19:0] p);
        logic [15:0] e1, e2;
        e1 = rdmem(r + {10'd0, v[15:14]});
        f = 0; p = '0;
        if (!e1[15]) f = 1;
        else if (e1[14]) p = {e1[7:2], v[13:0]};
        else begin
            e2 = rdmem(e1[11:0] + {10'd0, v[13:12]});
            if (!e2[15]) f = 1;
            else p = {e2[7:0], v[11:0]};
        end
    endtask

    task automatic walk(input logic [15:0] v, input logic [11:0] r, input int l,
                        input string t, input bit poke);
        logic        ef;
        logic [19:0] ep;
        gold(v, r, ef, ep);
        tag = t;
        lat = l;
        done_cnt = 0;
        n_va = v; n_root = r; n_start = 1'b1;
        cycle();
        n_start = 1'b0;
        if (poke) begin
            n_start = 1'b1; n_va = ~v; n_root = r + 12'd5;
            cycle();
            n_start = 1'b0;
        end
        for (int k = 0; k < 60 && done_cnt == 0; k++) cycle();
        cycle();
        n_va = v; n_root = r;
        chk({t, " done count"}, done_cnt == 1, done_cnt, 1);
        chk({t, " fault"}, got_fault === ef, got_fault, ef);
        chk({t, " pa"}, got_pa === ep, got_pa, ep);
    endtask

    initial begin
        #(20 * 100000);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        // root table A at 0x010
        mem[12'h010] = 16'h8100; mem[12'h011] = 16'h8400;
        mem[12'h012] = 16'h8300; mem[12'h013] = 16'h8700;
        for (int i = 0; i < 4; i++) begin
            logic [7:0] f1, f3, f4, f7;
            f1 = (i == 0) ? 8'h06 : (i == 1) ? 8'h08 : (i == 2) ? 8'h07 : 8'h09;
            f4 = (i == 0) ? 8'h00 : (i == 1) ? 8'h05 : (i == 2) ? 8'h10 : 8'h12;
            f3 = (i == 0) ? 8'h02 : (i == 1) ? 8'h01 : (i == 2) ? 8'h04 : 8'h03;
            f7 = (i == 0) ? 8'h11 : (i == 1) ? 8'h13 : (i == 2) ? 8'h15 : 8'h14;
            mem[12'h100 + i] = {8'h80, f1};
            mem[12'h400 + i] = {8'h80, f4};
            mem[12'h300 + i] = {8'h80, f3};
            mem[12'h700 + i] = {8'h80, f7};
        end
        // root table B at 0x020: null, normal, large page, normal
        mem[12'h020] = 16'h0000; mem[12'h021] = 16'h8100;
        mem[12'h022] = 16'hC0A4; mem[12'h023] = 16'h8500;
        mem[12'h500] = 16'h8033; mem[12'h501] = 16'h0077;
        mem[12'h502] = 16'h80C1; mem[12'h503] = 16'h80C2;

        tag = "R1";
        n_rst = 1'b1;
        repeat (3) cycle();
        chk("R1 reset done", done === 1'b0, done, 0);
        chk("R1 reset req", mem_req === 1'b0, mem_req, 0);
        n_rst = 1'b0;
        cycle();
        chk("R1 after reset quiet", (done === 1'b0) && (fault === 1'b0) && (mem_req === 1'b0), done, 0);

        walk(16'h9B4E, 12'h010, 1, "R4 example 39758", 0);
        chk("R4 example value", got_pa === 20'd6990, got_pa, 6990);
        walk(16'h0123, 12'h010, 2, "R3 l1 idx0", 0);
        walk(16'h7FFF, 12'h010, 3, "R9 latency3", 0);
        walk(16'hE001, 12'h010, 5, "R9 latency5", 0);
        walk(16'h5ABC, 12'h010, 1, "R2 root A", 0);
        chk("R2 root A value", got_pa === 20'h05ABC, got_pa, 20'h05ABC);
        walk(16'h5ABC, 12'h020, 1, "R2 root B", 0);
        chk("R2 root B value", got_pa === 20'h08ABC, got_pa, 20'h08ABC);
        walk(16'h0FFF, 12'h020, 2, "R5 null root entry", 0);
        walk(16'hD555, 12'h020, 1, "R5 null leaf entry", 0);
        walk(16'hB123, 12'h020, 2, "R6 large page", 0);
        chk("R6 large page value", got_pa === 20'hA7123, got_pa, 20'hA7123);
        walk(16'h8FED, 12'h020, 1, "R6 large page low", 0);
        walk(16'h6321, 12'h010, 3, "R7 start while busy", 1);
        walk(16'hF0F0, 12'h020, 2, "R7 root change mid-walk", 1);

        tag = "R8 early response";
        early_junk = 1;
        walk(16'h2468, 12'h010, 2, "R8 response with request", 0);
        early_junk = 0;

        tag = "R8 stray while idle";
        done_cnt = 0;
        stray_idle = 1;
        repeat (4) cycle();
        stray_idle = 0;
        repeat (2) cycle();
        chk("R8 stray while idle", done_cnt == 0, done_cnt, 0);

        walk(16'h4000, 12'h010, 1, "R3 after stray", 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule